// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block is one DMA channel. It copies a programmed number of bytes from a source address to a destination address over a shared memory bus. Either side may be pinned to one address, which suits a peripheral FIFO. Software programs four 32-bit registers and then sets the enable bit. The channel moves data in bursts. Before each burst it waits until every non-memory side has raised its request line. While it runs, software can read how much of the transfer is left.

On the memory bus each word takes one read from the source and then one write of that same word to the destination. Both accesses use a valid/ready handshake. When the last word has been written, the channel clears its own enable bit. If software asked for it, the channel also gives a one-cycle done pulse. Clearing enable while a transfer is running stops the channel on the spot. The remaining count is kept so that software can read it.

Top module: `pdma_channel`

## Requirements
- R1: `reg_sel` picks a register: 0 = source address (byte offset 0x0), 1 = destination address (0x4), 2 = control word A (0x8), 3 = control word B (0xC). Source and destination read back exactly as written. Control word B keeps these fields: bits 25:22 (segment), 21:16 (source request id), 14 (continuous), 13:8 (destination request id), 7:3 (next id), 2 (coherent), 1 (fail) and 0 (mask). Bits 31:26 and bit 15 always read 0. After reset every register reads 0.
- R2: Control word A holds these fields: bits 31:16 = byte length, 15:8 = remaining count (read-only, writes to it are ignored), 7 = source fixed, 6 = destination fixed, 5:3 = burst code, 2 = done-pulse enable, 1 = enable, 0 = hardware-mode flag. The hardware-mode flag is stored and read back.
- R3: Burst codes 0, 1, 2 and 3 give bursts of 4, 8, 16 and 32 bytes (1, 2, 4 and 8 words). Codes 4 to 7 act as code 3. The last burst may be shorter.
- R4: A transfer starts only when enable = 1 and mask = 0. While mask is 1 the enabled channel makes no bus access. Clearing mask lets the transfer start.
- R5: Each word is read from the current source address and then written to the current destination address. After each word, an address that is not fixed advances by 4. A fixed address stays constant for the whole transfer.
- R6: Request id 32 marks the memory side, which is always ready. An id below NREQ selects `req_i[id]`. Any other id is never ready. Before its first access, each burst waits until both sides are ready.
- R7: The remaining count equals the remaining bytes divided by 2^(1+code), rounded up and saturated at 255. Here code is the burst code after the adjustment of R3.
- R8: Bits 1:0 of the length are ignored. A length below 4 completes at once with no bus access.
- R9: On completion the enable bit reads 0. If done-pulse enable is 1, `done_o` is high for exactly one cycle; otherwise it stays low.
- R10: If enable is cleared during a transfer, `mem_valid` drops and no further access happens. The remaining count keeps the value it had when the channel stopped.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register word select (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| req_i | input | NREQ | Peripheral request lines |
| mem_valid | output | 1 | Bus access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_ready | input | 1 | Bus accepts the access this cycle |
| mem_rdata | input | 32 | Bus read data, valid with `mem_ready` on a read |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A table of transfers covers four cases: memory to memory, memory to a fixed FIFO address, a fixed FIFO address to memory, and a single word. Across these rows the burst code and the length are varied, and one row uses a burst code above 3. A fixed-address row shows that the pinned side does not move while the other side advances. FIFO pop numbering shows the order of the reads, and a length that is not a whole number of bursts exercises the short last burst. Directed tests hold a request line low to show that the channel stalls at a burst boundary, read the live count for several burst codes (including saturation), abort a transfer partway, and cover zero length, mask gating and a suppressed done pulse.

// File: rtl/pdma_pkg.sv
// Package for the DMA channel: register width, engine states and the
// burst-code adjustment. Assumes a 32-bit register and bus word.
package pdma_pkg;
    localparam int REG_W      = 32;
    localparam int ID_W       = 6;
    localparam int MEM_REQ_ID = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_WR
    } eng_state_t;

    // Codes above 3 behave like the 32-byte burst.
    function automatic logic [1:0] clamp_code(input logic [2:0] code);
        return code[2] ? 2'd3 : code[1:0];
    endfunction
endpackage

// File: rtl/pdma_regs.sv
// Register file of the channel: two address words and two control words.
// The remaining-count field is supplied live by the engine. The engine
// clears the enable bit on completion, and that clear wins over a write
// in the same cycle.
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [1:0]       sel_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             clr_en_i,
    output logic [REG_W-1:0] src_addr_o,
    output logic [REG_W-1:0] dst_addr_o,
    output logic [LEN_W-3:0] len_words_o,
    output logic             src_fixed_o,
    output logic             dst_fixed_o,
    output logic [2:0]       burst_code_o,
    output logic             done_ie_o,
    output logic             en_o,
    output logic [ID_W-1:0]  src_id_o,
    output logic [ID_W-1:0]  dst_id_o,
    output logic             mask_o
);
    localparam logic [REG_W-1:0] CTLB_KEEP = 32'h03FF_7FFF;

    logic [REG_W-1:0] src_q, dst_q, ctlb_q;
    logic [LEN_W-1:0] len_q;
    logic             sfix_q, dfix_q, ie_q, en_q, hw_q;
    logic [2:0]       code_q;

    // Register writes, plus the enable clear issued by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            ctlb_q <= '0;
            len_q  <= '0;
            sfix_q <= 1'b0;
            dfix_q <= 1'b0;
            code_q <= '0;
            ie_q   <= 1'b0;
            en_q   <= 1'b0;
            hw_q   <= 1'b0;
        end else begin
            if (we_i) begin
                case (sel_i)
                    2'd0: src_q  <= wdata_i;
                    2'd1: dst_q  <= wdata_i;
                    2'd2: begin
                        len_q  <= wdata_i[31:16];
                        sfix_q <= wdata_i[7];
                        dfix_q <= wdata_i[6];
                        code_q <= wdata_i[5:3];
                        ie_q   <= wdata_i[2];
                        en_q   <= wdata_i[1];
                        hw_q   <= wdata_i[0];
                    end
                    default: ctlb_q <= wdata_i & CTLB_KEEP;
                endcase
            end
            if (clr_en_i) en_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (sel_i)
            2'd0:    rdata_o = src_q;
            2'd1:    rdata_o = dst_q;
            2'd2:    rdata_o = {len_q, cnt_i, sfix_q, dfix_q, code_q, ie_q, en_q, hw_q};
            default: rdata_o = ctlb_q;
        endcase
    end

    assign src_addr_o   = src_q;
    assign dst_addr_o   = dst_q;
    assign len_words_o  = len_q[LEN_W-1:2];
    assign src_fixed_o  = sfix_q;
    assign dst_fixed_o  = dfix_q;
    assign burst_code_o = code_q;
    assign done_ie_o    = ie_q;
    assign en_o         = en_q;
    assign src_id_o     = ctlb_q[21:16];
    assign dst_id_o     = ctlb_q[13:8];
    assign mask_o       = ctlb_q[0];

    // R9: a completion clear leaves enable low on the next cycle.
    p_clear_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> !en_o);
endmodule

// File: rtl/pdma_reqsel.sv
// Turns one side's request id into a ready flag. Id 32 is the memory side
// and is always ready. An id below NREQ follows that request line. Any
// other id never becomes ready. Assumes NREQ <= 32.
module pdma_reqsel
    import pdma_pkg::*;
#(
    parameter int NREQ = 8
) (
    input  logic [ID_W-1:0] id_i,
    input  logic [NREQ-1:0] req_i,
    output logic            rdy_o
);
    // Decode the id against the memory marker and each request line.
    always_comb begin
        rdy_o = (id_i == ID_W'(MEM_REQ_ID));
        for (int i = 0; i < NREQ; i++) begin
            if (id_i == ID_W'(i)) rdy_o = req_i[i];
        end
    end
endmodule

// File: rtl/pdma_engine.sv
// Transfer engine. It latches the addresses and the word count when it
// starts. Each burst waits for both sides to be ready, then each word is
// read from the source and written to the destination. The engine reports
// the remaining count and signals completion. Assumes that software does
// not rewrite the address registers while a transfer runs.
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             mask_i,
    input  logic [LEN_W-3:0] len_words_i,
    input  logic             src_fixed_i,
    input  logic             dst_fixed_i,
    input  logic [2:0]       burst_code_i,
    input  logic             done_ie_i,
    input  logic [REG_W-1:0] src_addr_i,
    input  logic [REG_W-1:0] dst_addr_i,
    input  logic             src_rdy_i,
    input  logic             dst_rdy_i,
    output logic             mem_valid,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [REG_W-1:0] mem_wdata,
    input  logic             mem_ready,
    input  logic [REG_W-1:0] mem_rdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic             clr_en_o,
    output logic             done_o
);
    localparam int WCNT_W = LEN_W - 2;
    localparam int BEAT_W = 4;

    eng_state_t       state_q;
    logic [REG_W-1:0] cur_src_q, cur_dst_q, hold_q;
    logic [WCNT_W-1:0] rem_q;
    logic [BEAT_W-1:0] beat_q;
    logic             done_q;

    logic [1:0]        code_c;
    logic [BEAT_W-1:0] bw_c, first_beat_c;
    logic              start_ok, busy, last_wr, zero_start;
    logic [2:0]        sh_c;
    logic [LEN_W-1:0]  rem_bytes_c;
    logic [LEN_W:0]    units_c;

    // Burst size in words, and the length of the next burst.
    always_comb begin
        code_c = clamp_code(burst_code_i);
        bw_c   = BEAT_W'(1) << code_c;
        first_beat_c = (rem_q < WCNT_W'(bw_c)) ? rem_q[BEAT_W-1:0] : bw_c;
    end

    // Start, completion and busy conditions.
    always_comb begin
        start_ok   = en_i && !mask_i;
        busy       = (state_q != ST_IDLE);
        last_wr    = (state_q == ST_WR) && en_i && mem_ready && (rem_q == WCNT_W'(1));
        zero_start = (state_q == ST_IDLE) && start_ok && (len_words_i == '0);
        clr_en_o   = last_wr || zero_start;
    end

    // Live remaining count in units of 2^(1+code) bytes, rounded up and saturated.
    always_comb begin
        sh_c        = 3'(code_c) + 3'd1;
        rem_bytes_c = {rem_q, 2'b00};
        units_c     = ({1'b0, rem_bytes_c} + (((LEN_W+1)'(1)) << sh_c) - (LEN_W+1)'(1)) >> sh_c;
        cnt_o       = (|units_c[LEN_W:CNT_W]) ? '1 : units_c[CNT_W-1:0];
    end

    // Transfer sequencing: load, wait for request, read, write, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_src_q <= '0;
            cur_dst_q <= '0;
            hold_q    <= '0;
            rem_q     <= '0;
            beat_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_ok && (len_words_i != '0)) begin
                        cur_src_q <= src_addr_i;
                        cur_dst_q <= dst_addr_i;
                        rem_q     <= len_words_i;
                        state_q   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!en_i) state_q <= ST_IDLE;
                    else if (src_rdy_i && dst_rdy_i) begin
                        beat_q  <= first_beat_c;
                        state_q <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (!en_i) state_q <= ST_IDLE;
                    else if (mem_ready) begin
                        hold_q  <= mem_rdata;
                        state_q <= ST_WR;
                    end
                end
                default: begin
                    if (!en_i) state_q <= ST_IDLE;
                    else if (mem_ready) begin
                        rem_q  <= rem_q - WCNT_W'(1);
                        beat_q <= beat_q - BEAT_W'(1);
                        if (!src_fixed_i) cur_src_q <= cur_src_q + REG_W'(4);
                        if (!dst_fixed_i) cur_dst_q <= cur_dst_q + REG_W'(4);
                        if (rem_q == WCNT_W'(1))        state_q <= ST_IDLE;
                        else if (beat_q == BEAT_W'(1))  state_q <= ST_WAIT;
                        else                            state_q <= ST_RD;
                    end
                end
            endcase
        end
    end

    // Registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= clr_en_o && done_ie_i;
    end

    assign done_o    = done_q;
    assign mem_valid = ((state_q == ST_RD) || (state_q == ST_WR)) && en_i;
    assign mem_we    = (state_q == ST_WR);
    assign mem_addr  = (state_q == ST_WR) ? cur_dst_q : cur_src_q;
    assign mem_wdata = hold_q;

    // R4: the engine leaves idle only after an enabled, unmasked cycle.
    p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en_i && !mask_i));
    // R5: a fixed source keeps every read on the programmed address.
    p_fixed_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we && src_fixed_i) |-> (mem_addr == src_addr_i));
    // R6: a burst begins only when both sides were ready.
    p_req_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD && $past(state_q) == ST_WAIT) |-> $past(src_rdy_i && dst_rdy_i));
    // R9: the done pulse lasts one cycle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10: clearing enable stops the engine on the next edge.
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en_i) |=> !busy);
    // R11: a stalled access is held steady.
    p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (!en_i || (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))));
endmodule

// File: rtl/pdma_channel.sv
// Top of the single DMA channel. It connects the register file, one request
// selector per side and the transfer engine. Register accesses are single
// cycle. The bus is a valid/ready port shared by the reads and the writes.
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int NREQ  = 8,
    parameter int LEN_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NREQ-1:0]  req_i,
    output logic             mem_valid,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [REG_W-1:0] mem_wdata,
    input  logic             mem_ready,
    input  logic [REG_W-1:0] mem_rdata,
    output logic             done_o
);
    logic [REG_W-1:0] src_addr, dst_addr;
    logic [LEN_W-3:0] len_words;
    logic             src_fixed, dst_fixed, done_ie, en, mask, clr_en;
    logic [2:0]       burst_code;
    logic [ID_W-1:0]  src_id, dst_id;
    logic             src_rdy, dst_rdy;
    logic [CNT_W-1:0] cnt;

    pdma_regs #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .sel_i(reg_sel),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .cnt_i(cnt), .clr_en_i(clr_en),
        .src_addr_o(src_addr), .dst_addr_o(dst_addr), .len_words_o(len_words),
        .src_fixed_o(src_fixed), .dst_fixed_o(dst_fixed), .burst_code_o(burst_code),
        .done_ie_o(done_ie), .en_o(en), .src_id_o(src_id), .dst_id_o(dst_id),
        .mask_o(mask)
    );

    pdma_reqsel #(.NREQ(NREQ)) u_src_sel (.id_i(src_id), .req_i(req_i), .rdy_o(src_rdy));
    pdma_reqsel #(.NREQ(NREQ)) u_dst_sel (.id_i(dst_id), .req_i(req_i), .rdy_o(dst_rdy));

    pdma_engine #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .en_i(en), .mask_i(mask), .len_words_i(len_words),
        .src_fixed_i(src_fixed), .dst_fixed_i(dst_fixed), .burst_code_i(burst_code),
        .done_ie_i(done_ie), .src_addr_i(src_addr), .dst_addr_i(dst_addr),
        .src_rdy_i(src_rdy), .dst_rdy_i(dst_rdy), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .cnt_o(cnt),
        .clr_en_o(clr_en), .done_o(done_o)
    );
endmodule

// File: tb/sim_pdma_channel.sv
`timescale 1ns/100ps
// Bench for pdma_channel. A table of transfers is walked first, then
// directed tests follow. The bus model has memory below 0x2000 and a FIFO
// at addresses with bit 13 set.
module sim_pdma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  req_i = 8'hFF;
    logic        mem_valid, mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        done_o;

    always #2.5 clk = ~clk;

    pdma_channel u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_i(req_i),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .done_o(done_o)
    );

    typedef struct packed {
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] len;
        logic [2:0]  code;
        logic        sfix;
        logic        dfix;
        logic [5:0]  sid;
        logic [5:0]  did;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h0100, 16'h0400, 16'd16, 3'd0, 1'b0, 1'b0, 6'd32, 6'd32},
        '{16'h0200, 16'h2000, 16'd32, 3'd1, 1'b0, 1'b1, 6'd32, 6'd2},
        '{16'h2000, 16'h0600, 16'd24, 3'd2, 1'b1, 1'b0, 6'd1,  6'd32},
        '{16'h0300, 16'h2000, 16'd40, 3'd3, 1'b0, 1'b1, 6'd32, 6'd5},
        '{16'h0080, 16'h0700, 16'd4,  3'd0, 1'b0, 1'b0, 6'd32, 6'd32},
        '{16'h0140, 16'h0800, 16'd36, 3'd6, 1'b0, 1'b0, 6'd32, 6'd32}
    };

    int n_chk = 0, n_fail = 0;
    int tick = 0, wn = 0, rn = 0, pop_cnt = 0, done_cnt = 0, hold_bad = 0;
    logic [31:0] mem [1024];
    logic [31:0] wlog_a [64];
    logic [31:0] wlog_d [64];
    bit          pend = 1'b0;
    logic [31:0] p_addr, p_wd;
    logic        p_we;

    // Bus model, request sampling and pulse counting, all at the falling edge.
    always @(negedge clk) begin
        bit rdy;
        tick++;
        if (pend && mem_valid && (mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wd))
            hold_bad++;
        rdy = (tick % 3) != 0;
        mem_ready = rdy;
        if (mem_valid && rdy) begin
            if (mem_we) begin
                if (wn < 64) begin wlog_a[wn] = mem_addr; wlog_d[wn] = mem_wdata; end
                wn++;
                if (!mem_addr[13]) mem[mem_addr[11:2]] = mem_wdata;
            end else begin
                rn++;
                if (mem_addr[13]) begin mem_rdata = 32'hF1F0_0000 + pop_cnt; pop_cnt++; end
                else mem_rdata = mem[mem_addr[11:2]];
            end
        end
        pend = mem_valid && !rdy;
        p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
        if (done_o) done_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_a(input logic [15:0] len, input logic sf, input logic df,
                                         input logic [2:0] code, input logic ie, input logic en);
        return {len, 8'h00, sf, df, code, ie, en, 1'b0};
    endfunction

    function automatic logic [31:0] mk_b(input logic [5:0] sid, input logic [5:0] did, input logic mask);
        return (32'(sid) << 16) | (32'(did) << 8) | 32'(mask);
    endfunction

    task automatic clear_log();
        for (int i = 0; i < 1024; i++) mem[i] = 32'h1000_0000 + i;
        wn = 0; rn = 0;
    endtask

    task automatic wait_done(input int d0, input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            #1;
            if (done_cnt > d0) begin ok = 1'b1; break; end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit ok;
        int d0, pb, words, bad;
        logic [31:0] ea, ed;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: reset state of all registers and outputs.
        for (int s = 0; s < 4; s++) begin
            reg_rd(2'(s), rd);
            check(rd == 32'h0, "R1 reset register value", rd, 32'h0);
        end
        check(!mem_valid && !done_o, "R9 outputs idle after reset", {30'h0, mem_valid, done_o}, 32'h0);

        // R1: read back of the address words and masked control word B.
        reg_wr(2'd0, 32'h1234_5678);
        reg_rd(2'd0, rd);
        check(rd == 32'h1234_5678, "R1 source readback", rd, 32'h1234_5678);
        reg_wr(2'd3, 32'hFFFF_FFFF);
        reg_rd(2'd3, rd);
        check(rd == 32'h03FF_7FFF, "R1 control B field mask", rd, 32'h03FF_7FFF);
        // R2: count field is read-only, other fields and hardware-mode bit stored.
        reg_wr(2'd2, 32'hABCD_FFFD);
        reg_rd(2'd2, rd);
        check(rd == 32'hABCD_00FD, "R2 control A layout", rd, 32'hABCD_00FD);
        reg_wr(2'd2, 32'h0);

        // R5/R3/R6/R9: table of transfers.
        foreach (VECS[v]) begin
            clear_log();
            pb = pop_cnt;
            d0 = done_cnt;
            words = int'(VECS[v].len) >> 2;
            reg_wr(2'd0, 32'(VECS[v].src));
            reg_wr(2'd1, 32'(VECS[v].dst));
            reg_wr(2'd3, mk_b(VECS[v].sid, VECS[v].did, 1'b0));
            reg_wr(2'd2, mk_a(VECS[v].len, VECS[v].sfix, VECS[v].dfix, VECS[v].code, 1'b1, 1'b1));
            wait_done(d0, 3000, ok);
            check(ok, "R9 done pulse after transfer", 32'(ok), 32'h1);
            idle(2);
            check(wn == words && rn == words, "R5 access count", 32'(wn), 32'(words));
            bad = 0;
            for (int k = 0; k < words && k < 64; k++) begin
                ea = 32'(VECS[v].dst) + (VECS[v].dfix ? 32'h0 : 32'(4 * k));
                ed = VECS[v].sfix ? 32'hF1F0_0000 + 32'(pb + k)
                                  : 32'h1000_0000 + 32'(VECS[v].src >> 2) + 32'(k);
                if (wlog_a[k] !== ea || wlog_d[k] !== ed) begin
                    bad++;
                    $display("FAIL R5 word %0d actual=%h/%h expected=%h/%h", k, wlog_a[k], wlog_d[k], ea, ed);
                end
            end
            n_chk++;
            if (bad != 0) n_fail++;
            reg_rd(2'd2, rd);
            check(rd[1] == 1'b0, "R9 enable cleared on completion", 32'(rd[1]), 32'h0);
            check(rd[15:8] == 8'd0, "R7 count zero after completion", 32'(rd[15:8]), 32'h0);
        end

        // R4: mask holds an enabled channel; clearing mask starts it.
        clear_log();
        d0 = done_cnt;
        reg_wr(2'd0, 32'h0100);
        reg_wr(2'd1, 32'h0400);
        reg_wr(2'd3, mk_b(6'd32, 6'd32, 1'b1));
        reg_wr(2'd2, mk_a(16'd16, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1));
        idle(20);
        check(wn == 0 && rn == 0, "R4 no access while masked", 32'(wn + rn), 32'h0);
        reg_wr(2'd3, mk_b(6'd32, 6'd32, 1'b0));
        wait_done(d0, 2000, ok);
        idle(2);
        check(ok && wn == 4, "R4 runs after mask cleared", 32'(wn), 32'd4);

        // R6/R3/R7/R10: request wait, burst boundary, live count, abort.
        clear_log();
        req_i[3] = 1'b0;
        reg_wr(2'd0, 32'h0100);
        reg_wr(2'd1, 32'h2000);
        reg_wr(2'd3, mk_b(6'd32, 6'd3, 1'b0));
        reg_wr(2'd2, mk_a(16'd40, 1'b0, 1'b1, 3'd1, 1'b1, 1'b1));
        idle(20);
        check(rn == 0 && wn == 0, "R6 waits for request line", 32'(rn), 32'h0);
        reg_rd(2'd2, rd);
        check(rd[15:8] == 8'd10, "R7 count for 40 bytes code 1", 32'(rd[15:8]), 32'd10);
        req_i[3] = 1'b1;
        for (int i = 0; i < 100 && rn == 0; i++) idle(1);
        req_i[3] = 1'b0;
        idle(30);
        check(wn == 2, "R3 one 8-byte burst per request", 32'(wn), 32'd2);
        reg_rd(2'd2, rd);
        check(rd[15:8] == 8'd8, "R7 count after one burst", 32'(rd[15:8]), 32'd8);
        reg_wr(2'd2, mk_a(16'd40, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0));
        req_i[3] = 1'b1;
        idle(20);
        check(wn == 2 && !mem_valid, "R10 no access after abort", 32'(wn), 32'd2);
        reg_rd(2'd2, rd);
        check(rd[15:8] == 8'd8, "R10 count retained after abort", 32'(rd[15:8]), 32'd8);

        // R3/R7: code above 3 acts as 32-byte; count saturates at 255.
        req_i[3] = 1'b0;
        reg_wr(2'd2, mk_a(16'd64, 1'b0, 1'b1, 3'd6, 1'b1, 1'b1));
        idle(3);
        reg_rd(2'd2, rd);
        check(rd[15:8] == 8'd4, "R3 code 6 counts in 16-byte units", 32'(rd[15:8]), 32'd4);
        reg_wr(2'd2, mk_a(16'd64, 1'b0, 1'b1, 3'd6, 1'b1, 1'b0));
        reg_wr(2'd2, mk_a(16'hFFFC, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1));
        idle(3);
        reg_rd(2'd2, rd);
        check(rd[15:8] == 8'd255, "R7 count saturates", 32'(rd[15:8]), 32'd255);
        reg_wr(2'd2, mk_a(16'hFFFC, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0));
        req_i[3] = 1'b1;

        // R8: lengths 0 and 3 finish with no bus access.
        for (int z = 0; z < 2; z++) begin
            clear_log();
            d0 = done_cnt;
            reg_wr(2'd3, mk_b(6'd32, 6'd32, 1'b0));
            reg_wr(2'd2, mk_a(16'(3 * z), 1'b0, 1'b0, 3'd0, 1'b1, 1'b1));
            wait_done(d0, 20, ok);
            idle(3);
            check(ok && wn == 0 && rn == 0, "R8 short length completes without access", 32'(wn + rn), 32'h0);
            reg_rd(2'd2, rd);
            check(rd[1] == 1'b0, "R8 enable cleared for short length", 32'(rd[1]), 32'h0);
        end

        // R9: no done pulse when the pulse enable is clear.
        clear_log();
        d0 = done_cnt;
        reg_wr(2'd0, 32'h0100);
        reg_wr(2'd1, 32'h0400);
        reg_wr(2'd2, mk_a(16'd8, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1));
        rd = 32'h2;
        for (int i = 0; i < 300 && rd[1]; i++) reg_rd(2'd2, rd);
        idle(3);
        check(rd[1] == 1'b0 && wn == 2, "R9 completes with pulse disabled", 32'(wn), 32'd2);
        check(done_cnt == d0, "R9 no pulse when disabled", 32'(done_cnt - d0), 32'h0);

        // R11: stalled accesses were held steady throughout.
        check(hold_bad == 0, "R11 stalled access stable", 32'(hold_bad), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule